// File: doc/BRIEF.md
# Segmented Set-Before-First Mask Unit

This unit turns a source word into a predicate mask. It walks the source from the least significant bit upward and writes a one into every result position until it reaches the first set source bit. From that bit upward the result is zero. A second operand, the restart mask, can switch the setting behaviour back on at chosen bit positions. Each restart bit therefore opens a new segment, and each segment gets its own set-before-first result.

The caller can also declare that the restart operand is the hardwired zero register. In that case the restart mask is replaced by a word that has only bit 0 set, so setting starts at bit 0 and no later restart happens. The result is registered. It appears one clock after the input strobe, together with a valid flag. When no strobe is given, the last result is held. The scan is built either as a plain ripple loop or as a carry chain folded into one addition. A parameter chooses between them, and both produce the same result.

Top module: `sbf_mask_unit`

## Requirements
- R1: While rst_n is low, out_valid and out_mask are zero, and they go to zero at once when rst_n falls.
- R2: out_valid after a rising clock edge equals in_valid sampled at that edge, and out_mask carries the result for the operands presented at the same edge (one cycle of latency).
- R3: With in_restart_zero=1, out_mask bits below the lowest set bit of in_src are 1, and that bit and every bit above it are 0.
- R4: With in_restart_zero=1 and in_src all zero, out_mask is all ones.
- R5: With in_restart_zero=1 and in_src bit 0 set, out_mask is all zeros.
- R6: With in_restart_zero=1, in_restart has no effect: the result equals that of in_restart_zero=0 with a restart mask that has only bit 0 set.
- R7: With in_restart_zero=0, setting is active at bit 0 only if in_restart bit 0 is 1, so an all-zero restart mask gives an all-zero result.
- R8: With in_restart_zero=0, a restart bit of 1 at position i turns setting on before source bit i is examined, so out_mask bit i equals the inverse of in_src bit i. Ones then continue upward while the source bits stay zero.
- R9: In setting mode a set source bit gives a 0 and ends setting. The result then stays 0 until the next restart bit, so no result bit is set where the source bit is set. For src=0x94 and restart=0xC3, the result is 0x43.
- R10: While in_valid is low, out_mask keeps its previous value.
- R11: The ripple variant and the carry-chain variant give identical outputs for the same operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands present this cycle |
| in_src | input | XLEN | Source word that is scanned for set bits |
| in_restart | input | XLEN | Restart mask; a 1 turns setting on at that bit |
| in_restart_zero | input | 1 | Restart operand is the zero register; in_restart is ignored |
| out_valid | output | 1 | Registered result is new this cycle |
| out_mask | output | XLEN | Registered result mask |

## Verification
With the zero-register flag set, the source patterns are empty, bit-0-only, all-ones, top-bit-only and a middle bit. These separate a correct stop at the first set bit from a scan that stops too early, runs off the top, or ignores the implicit start at bit 0. A junk restart mask is then applied with the flag set, to show that the mask is ignored. With the flag clear, the patterns include:
- an empty restart mask, to confirm that nothing starts on its own;
- a restart at bit 0 only, which must match the flag case;
- a restart in the middle of the word, both on a clear source bit and on a set one;
- two independent segments;
- the mixed eight-bit case.

Together these expose a mode that leaks across segments or a restart that is applied after the source bit instead of before it. Every vector is also fed to both scan variants and their outputs are compared.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // How the bit-serial recurrence is realised in hardware
    typedef enum logic [0:0] {
        SCAN_RIPPLE = 1'b0,   // explicit per-bit loop
        SCAN_ADDER  = 1'b1    // recurrence mapped onto an adder carry chain
    } scan_kind_e;
endpackage

// File: rtl/sbf_operand_prep.sv
// Turns the operands into per-bit start (gen) and continue (prop) terms.
// The zero-register case is folded in as a restart mask holding only bit 0.
module sbf_operand_prep #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] restart,
    input  logic            restart_zero,
    output logic [XLEN-1:0] gen,
    output logic [XLEN-1:0] prop
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [XLEN-1:0] START_ONLY = XLEN'(1);

    logic [XLEN-1:0] restart_eff;

    always_comb begin
        restart_eff = restart_zero ? START_ONLY : restart;
        prop        = ~src;
        gen         = restart_eff & ~src;
    end
endmodule

// File: rtl/sbf_scan.sv
// Resolves y[i] = gen[i] | (prop[i] & y[i-1]) with y[-1] = 0.
module sbf_scan
    import sbf_pkg::*;
#(
    parameter int         XLEN      = 64,
    parameter scan_kind_e SCAN_KIND = SCAN_ADDER
) (
    input  logic [XLEN-1:0] gen,
    input  logic [XLEN-1:0] prop,
    output logic [XLEN-1:0] mask
);
    timeunit 1ns;
    timeprecision 1ps;

    generate
        if (SCAN_KIND == SCAN_RIPPLE) begin : g_ripple
            logic run;
            always_comb begin
                run = 1'b0;
                for (int i = 0; i < XLEN; i++) begin
                    run     = gen[i] | (prop[i] & run);
                    mask[i] = run;
                end
            end
        end else begin : g_adder
            // gen is a subset of prop, so prop+gen carries exactly along runs.
            // carry out of bit i is gen[i] | (prop[i] & ~sum[i]).
            logic [XLEN-1:0] sum;
            always_comb begin
                sum  = prop + gen;
                mask = gen | (prop & ~sum);
            end
        end
    endgenerate
endmodule

// File: rtl/sbf_mask_unit.sv
module sbf_mask_unit
    import sbf_pkg::*;
#(
    parameter int         XLEN      = 64,
    parameter scan_kind_e SCAN_KIND = SCAN_ADDER
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] in_src,
    input  logic [XLEN-1:0] in_restart,
    input  logic            in_restart_zero,
    output logic            out_valid,
    output logic [XLEN-1:0] out_mask
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] mask;
    } state_t;

    state_t st_d, st_q;

    logic [XLEN-1:0] gen_w;
    logic [XLEN-1:0] prop_w;
    logic [XLEN-1:0] scan_w;

    sbf_operand_prep #(
        .XLEN (XLEN)
    ) u_prep (
        .src          (in_src),
        .restart      (in_restart),
        .restart_zero (in_restart_zero),
        .gen          (gen_w),
        .prop         (prop_w)
    );

    sbf_scan #(
        .XLEN      (XLEN),
        .SCAN_KIND (SCAN_KIND)
    ) u_scan (
        .gen  (gen_w),
        .prop (prop_w),
        .mask (scan_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.mask = scan_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_mask  = st_q.mask;
endmodule

// File: rtl/sbf_mask_unit_chk.sv
module sbf_mask_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [XLEN-1:0] in_src,
    input logic [XLEN-1:0] in_restart,
    input logic            in_restart_zero,
    input logic            out_valid,
    input logic [XLEN-1:0] out_mask
);
    timeunit 1ns;
    timeprecision 1ps;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                                   // R2
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                                 // R2
    AST_EMPTY_SRC_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_restart_zero && in_src == '0) |=> (out_mask == '1));      // R4
    AST_LSB_SRC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_restart_zero && in_src[0]) |=> (out_mask == '0));         // R5
    AST_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_restart_zero && in_restart == '0) |=> (out_mask == '0)); // R7
    AST_RESTART_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_restart_zero) |=>
        ((out_mask & $past(in_restart)) == (~$past(in_src) & $past(in_restart)))); // R8
    AST_DISJOINT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_mask & $past(in_src)) == '0));                        // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_mask));                                          // R10
endmodule

bind sbf_mask_unit sbf_mask_unit_chk #(
    .XLEN (XLEN)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_src          (in_src),
    .in_restart      (in_restart),
    .in_restart_zero (in_restart_zero),
    .out_valid       (out_valid),
    .out_mask        (out_mask)
);

// File: tb/tb_sbf_mask_unit.sv
module tb_sbf_mask_unit;
    import sbf_pkg::*;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W        = 64;
    localparam int N_VEC    = 14;
    localparam int WD_LIMIT = 200000;

    typedef struct packed {
        logic         zero;
        logic [W-1:0] src;
        logic [W-1:0] rst;
        logic [W-1:0] exp;
        logic [7:0]   req;
    } vec_t;

    // Hand-worked expected masks.
    localparam vec_t VECS [N_VEC] = '{
        '{1'b1, 64'h94,                  64'h0,                   64'h3,                   8'd3},  // R3 middle bit
        '{1'b1, 64'h8000_0000_0000_0000, 64'h0,                   64'h7FFF_FFFF_FFFF_FFFF, 8'd3},  // R3 top bit
        '{1'b1, 64'h100,                 64'h0,                   64'hFF,                  8'd3},  // R3
        '{1'b1, 64'h0,                   64'h0,                   64'hFFFF_FFFF_FFFF_FFFF, 8'd4},  // R4 empty source
        '{1'b1, 64'h1,                   64'h0,                   64'h0,                   8'd5},  // R5 bit 0 only
        '{1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,                   64'h0,                   8'd5},  // R5 all ones
        '{1'b1, 64'h94,                  64'hFFFF_0000_0000_00C3, 64'h3,                   8'd6},  // R6 junk restart
        '{1'b1, 64'h100,                 64'h0001_0000_0000_0000, 64'hFF,                  8'd6},  // R6
        '{1'b0, 64'h94,                  64'h0,                   64'h0,                   8'd7},  // R7 no start
        '{1'b0, 64'h94,                  64'h1,                   64'h3,                   8'd7},  // R7 start at bit 0
        '{1'b0, 64'h10,                  64'h100,                 64'hFFFF_FFFF_FFFF_FF00, 8'd8},  // R8 mid restart
        '{1'b0, 64'h1_0101,              64'h100,                 64'h0,                   8'd8},  // R8 restart on set bit
        '{1'b0, 64'h94,                  64'hC3,                  64'h43,                  8'd9},  // R9 mixed case
        '{1'b0, 64'h10_0000_0010,        64'h1_0000_0001,         64'hF_0000_000F,         8'd9}   // R9 two segments
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_src = '0;
    logic [W-1:0] in_restart = '0;
    logic         in_restart_zero = 1'b0;
    logic         out_valid, rpl_valid;
    logic [W-1:0] out_mask, rpl_mask;

    int n_checks = 0;
    int n_err    = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;  // 4 ns period

    sbf_mask_unit #(.XLEN(W), .SCAN_KIND(SCAN_ADDER)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src),
        .in_restart(in_restart), .in_restart_zero(in_restart_zero),
        .out_valid(out_valid), .out_mask(out_mask));

    sbf_mask_unit #(.XLEN(W), .SCAN_KIND(SCAN_RIPPLE)) dut_rpl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src),
        .in_restart(in_restart), .in_restart_zero(in_restart_zero),
        .out_valid(rpl_valid), .out_mask(rpl_mask));

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic v, input logic z, input logic [W-1:0] s, input logic [W-1:0] r);
        @(negedge clk);
        in_valid        = v;
        in_restart_zero = z;
        in_src          = s;
        in_restart      = r;
        @(negedge clk);
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] last;
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", W'(out_valid), '0);
        check("R1 reset out_mask", out_mask, '0);
        rst_n = 1'b1;

        for (int k = 0; k < N_VEC; k++) begin
            apply(1'b1, VECS[k].zero, VECS[k].src, VECS[k].rst);
            check($sformatf("R2 vec %0d valid", k), W'(out_valid), W'(1));
            check($sformatf("R%0d vec %0d mask", VECS[k].req, k), out_mask, VECS[k].exp);
            check($sformatf("R11 vec %0d ripple", k), rpl_mask, out_mask);
        end

        // R10 / R2: idle input with new operands must not disturb the result
        last = VECS[N_VEC-1].exp;
        apply(1'b0, 1'b1, 64'h0, 64'h0);
        check("R2 idle valid", W'(out_valid), '0);
        check("R10 hold mask", out_mask, last);
        apply(1'b0, 1'b0, 64'hFFFF, 64'h1);
        check("R10 hold mask again", out_mask, last);
        check("R11 ripple hold", W'(rpl_valid), '0);

        // R2 back-to-back strobes
        apply(1'b1, 1'b1, 64'h8, 64'h0);
        check("R2 first of pair", out_mask, 64'h7);
        apply(1'b1, 1'b0, 64'h0, 64'h8000_0000_0000_0000);
        check("R2 second of pair", out_mask, 64'h8000_0000_0000_0000);

        // R1 asynchronous reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 async out_valid", W'(out_valid), '0);
        check("R1 async out_mask", out_mask, '0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
        apply(1'b1, 1'b1, 64'h0, 64'h0);
        check("R4 after reset", out_mask, '1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule